// File: doc/BRIEF.md
# Sample-Locked Dither Ramp with Period-Aligned Averaging

This block produces a deterministic 4-bit dither code for a small resistor-ladder DAC that nudges the reference of an ADC front end. It also averages the two raw ADC channels, sine and cosine, over exactly one dither period. The code steps once per accepted ADC sample. It counts up through every value from 0 to 15 and then starts again at 0. Each decimation window is the 16 consecutive samples taken while the code ran from 0 to 15. Because of that, the periodic dither contributes the same fixed offset to every window and does not appear as ripple in the decimated stream.

At the nominal 250 kSps raw rate this gives about 15.6 k decimated sine/cosine pairs per second. That is ample for a DC to 4 kHz position signal that feeds an arctangent or tracking stage.

A small state machine follows the progress of each window through three states:
- `WIN_EMPTY`: no samples held, and the code is 0.
- `WIN_FILL`: between 1 and 14 samples held.
- `WIN_LAST`: 15 samples held, waiting for the final one.

Its transitions are:
- `start`: EMPTY to FILL, on the first sample.
- `nearly`: FILL to LAST, on the sample taken at code 14.
- `close`: LAST to EMPTY, on the sample taken at code 15, which publishes the result.

Top module: `dither_decim`

## Requirements
- R1: After reset the dither pins read 0, `avg_valid` is 0 and both averaged outputs read 0.
- R2: On every clock edge with `smp_valid` high, the dither code increases by one. Code 15 wraps to 0.
- R3: While `smp_valid` is low, the dither code does not change.
- R4: `avg_valid` is high for exactly one clock cycle, the cycle after the edge that takes the 16th sample of a window. It is never high on two cycles in a row.
- R5: Each averaged output equals (S + 8) >> 4 with an arithmetic shift, where S is the signed sum of the 16 two's-complement 12-bit samples of that channel in the window. The result is round-half-up to a 12-bit two's-complement word.
- R6: Each window holds exactly the samples taken at codes 0 through 15 in order. The dither code reads 0 while `avg_valid` is high.
- R7: Sixteen samples at full scale (all 2047 or all -2048) average to 2047 and -2048 respectively, with no wrap of the internal sum.
- R8: Between pulses of `avg_valid`, both averaged outputs hold their last published values.
- R9: Samples may arrive on consecutive clock cycles, including the cycle in which `avg_valid` is high, and none is lost.
- R10: The sine and cosine channels are averaged independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One raw sample pair is accepted on this edge |
| smp_sin | input | 12 | Raw sine sample, two's complement |
| smp_cos | input | 12 | Raw cosine sample, two's complement |
| dither_out | output | 4 | Dither code driving the DAC ladder |
| avg_valid | output | 1 | One-cycle strobe for a new averaged pair |
| avg_sin | output | 12 | Averaged sine, two's complement |
| avg_cos | output | 12 | Averaged cosine, two's complement |

## Verification
Directed windows in which a single sample carries a sum of 7, 8, -8 or -9 and all others are zero separate correct round-half-up from truncation or rounding toward zero. Windows of all 2047 and all -2048 expose a sum register that is too narrow or a shift that is not arithmetic. Different values on the two channels catch crossed or shared channel paths. A long run of random samples with random gaps of zero to three idle cycles checks the following together against a bench model:
- the code advance and hold,
- back-to-back acceptance in the strobe cycle,
- window alignment to code 0.

// File: rtl/dither_pkg.sv
`timescale 1ns/1ps
package dither_pkg;
    typedef enum logic [1:0] {
        WIN_EMPTY = 2'd0,
        WIN_FILL  = 2'd1,
        WIN_LAST  = 2'd2
    } win_state_t;
endpackage

// File: rtl/dither_seq.sv
`timescale 1ns/1ps
module dither_seq
    import dither_pkg::*;
#(
    parameter int STEP_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    output logic [STEP_BITS-1:0] code,
    output logic                 win_done
);
    localparam logic [STEP_BITS-1:0] TOP_CODE  = {STEP_BITS{1'b1}};
    localparam logic [STEP_BITS-1:0] NEAR_CODE = TOP_CODE - 1'b1;

    win_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WIN_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    // dither code register, stepping once per accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (take) begin
            code <= code + 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        win_done = 1'b0;
        unique case (state)
            WIN_EMPTY: begin
                if (take) state_nx = WIN_FILL;
            end
            WIN_FILL: begin
                if (take && code == NEAR_CODE) state_nx = WIN_LAST;
            end
            WIN_LAST: begin
                if (take) begin
                    state_nx = WIN_EMPTY;
                    win_done = 1'b1;
                end
            end
            default: state_nx = WIN_EMPTY;
        endcase
    end

    p_code_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> code == $past(code) + 1'b1);

    p_code_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(code));

    p_empty_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == WIN_EMPTY |-> code == '0);

    p_last_at_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == WIN_LAST |-> code == TOP_CODE);
endmodule

// File: rtl/chan_accum.sv
`timescale 1ns/1ps
module chan_accum #(
    parameter int SAMPLE_W  = 12,
    parameter int STEP_BITS = 4,
    parameter bit ROUND_EN  = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic                       close,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic signed [SAMPLE_W-1:0] avg
);
    localparam int ACC_W = SAMPLE_W + STEP_BITS;
    localparam logic signed [ACC_W-1:0] RND =
        ROUND_EN ? (ACC_W'(1) << (STEP_BITS - 1)) : '0;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] sum_nx;
    logic signed [ACC_W-1:0] rounded;
    logic signed [ACC_W-1:0] shifted;

    always_comb begin
        sum_nx  = acc + ACC_W'(sample);
        rounded = sum_nx + RND;
        shifted = rounded >>> STEP_BITS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            avg <= '0;
        end else if (take) begin
            if (close) begin
                acc <= '0;
                avg <= shifted[SAMPLE_W-1:0];
            end else begin
                acc <= sum_nx;
            end
        end
    end

    p_hold_avg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && close) |=> $stable(avg));

    p_cleared_after_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && close) |=> acc == '0);
endmodule

// File: rtl/dither_decim.sv
`timescale 1ns/1ps
module dither_decim #(
    parameter int SAMPLE_W  = 12,
    parameter int STEP_BITS = 4,
    parameter bit ROUND_EN  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_sin,
    input  logic [SAMPLE_W-1:0] smp_cos,
    output logic [STEP_BITS-1:0] dither_out,
    output logic                avg_valid,
    output logic [SAMPLE_W-1:0] avg_sin,
    output logic [SAMPLE_W-1:0] avg_cos
);
    localparam int NCH = 2;

    logic                       win_done;
    logic signed [SAMPLE_W-1:0] ch_in  [NCH];
    logic signed [SAMPLE_W-1:0] ch_out [NCH];

    assign ch_in[0] = smp_sin;
    assign ch_in[1] = smp_cos;
    assign avg_sin  = ch_out[0];
    assign avg_cos  = ch_out[1];

    dither_seq #(.STEP_BITS(STEP_BITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (smp_valid),
        .code     (dither_out),
        .win_done (win_done)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chan_accum #(
            .SAMPLE_W (SAMPLE_W),
            .STEP_BITS(STEP_BITS),
            .ROUND_EN (ROUND_EN)
        ) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (smp_valid),
            .close  (win_done),
            .sample (ch_in[g]),
            .avg    (ch_out[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_valid <= 1'b0;
        end else begin
            avg_valid <= win_done;
        end
    end

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |=> !avg_valid);

    p_valid_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |-> dither_out == '0);

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_valid |-> $stable(avg_sin) && $stable(avg_cos));
endmodule

// File: tb/dither_decim_tb.sv
`timescale 1ns/1ps
module dither_decim_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_sin = '0;
    logic [11:0] smp_cos = '0;
    logic [3:0]  dither_out;
    logic        avg_valid;
    logic [11:0] avg_sin;
    logic [11:0] avg_cos;

    int checks = 0;
    int errors = 0;
    int exp_code = 0;
    int n_in = 0;
    int sum_s = 0;
    int sum_c = 0;
    int last_s = 0;
    int last_c = 0;

    always #10 clk = ~clk;

    dither_decim u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_sin(smp_sin), .smp_cos(smp_cos),
        .dither_out(dither_out), .avg_valid(avg_valid),
        .avg_sin(avg_sin), .avg_cos(avg_cos)
    );

    function automatic int avg16(input int sum);
        return (sum + 8) >>> 4;
    endfunction

    function automatic int s12(input logic [11:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // drive one sample pair at a negedge, check one cycle later
    task automatic push(input int s, input int c);
        smp_valid = 1'b1;
        smp_sin   = 12'(s);
        smp_cos   = 12'(c);
        @(negedge clk);
        smp_valid = 1'b0;
        sum_s += s;
        sum_c += c;
        n_in++;
        exp_code = (exp_code + 1) % 16;
        chk(int'(dither_out) == exp_code, "R2 code step", int'(dither_out), exp_code);
        if (n_in == 16) begin
            last_s = avg16(sum_s);
            last_c = avg16(sum_c);
            chk(avg_valid == 1'b1, "R4 valid after 16th", int'(avg_valid), 1);
            chk(s12(avg_sin) == last_s, "R5/R10 sine avg", s12(avg_sin), last_s);
            chk(s12(avg_cos) == last_c, "R5/R10 cosine avg", s12(avg_cos), last_c);
            chk(dither_out == 4'd0, "R6 code zero at strobe", int'(dither_out), 0);
            n_in = 0; sum_s = 0; sum_c = 0;
        end else begin
            chk(avg_valid == 1'b0, "R4 no early valid", int'(avg_valid), 0);
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            chk(int'(dither_out) == exp_code, "R3 code hold", int'(dither_out), exp_code);
            chk(avg_valid == 1'b0, "R4 single pulse", int'(avg_valid), 0);
            chk(s12(avg_sin) == last_s, "R8 sine hold", s12(avg_sin), last_s);
            chk(s12(avg_cos) == last_c, "R8 cosine hold", s12(avg_cos), last_c);
        end
    endtask

    task automatic window_one(input int s, input int c);
        for (int i = 0; i < 16; i++) push(i == 0 ? s : 0, i == 0 ? c : 0);
        idle(1);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dither_out == 4'd0, "R1 reset code", int'(dither_out), 0);
        chk(avg_valid == 1'b0, "R1 reset valid", int'(avg_valid), 0);
        chk(avg_sin == 12'd0, "R1 reset sine", s12(avg_sin), 0);
        chk(avg_cos == 12'd0, "R1 reset cosine", s12(avg_cos), 0);
        idle(3);

        // rounding boundaries R5, channels different R10
        window_one(8, 7);
        window_one(-8, -9);
        window_one(24, -24);

        // ramp of values with back-to-back strobes R9
        for (int i = 0; i < 16; i++) push(i * 100 - 700, 700 - i * 37);
        idle(2);

        // full scale R7
        for (int i = 0; i < 16; i++) push(2047, -2048);
        idle(1);
        for (int i = 0; i < 16; i++) push(-2048, 2047);
        idle(1);

        // window with a long mid-window pause R3, R6
        for (int i = 0; i < 7; i++) push(i + 1, -i);
        idle(20);
        for (int i = 0; i < 9; i++) push(300, 5);
        idle(1);

        // random windows with random gaps R9
        for (int w = 0; w < 40; w++) begin
            for (int i = 0; i < 16; i++) begin
                push(s12(12'($urandom)), s12(12'($urandom)));
                idle(int'($urandom_range(0, 3)));
            end
        end
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule